// File: doc/BRIEF.md
# Settable Clock Calendar Counter

This block keeps the time of day and the calendar date as a chain of binary counters: seconds, minutes, hours, day of month, month and a two-digit year. A carry leaves each field when it wraps and enters the next field up. The length of the current month decides when the day wraps. The year runs from 00 to 99 and then wraps to 00 on a fixed century base. Seconds are derived from a sub-second strobe through a prescaler. A host can load each field on its own through a write port. A read request captures all six fields in one clock edge into a snapshot register, which the host then reads at leisure.

A test-advance request makes the chain run a full minute's worth of second ticks back to back, one per clock. This lets every rollover case, up to the end of the century, be reached within a few cycles of loading a time just short of it. While that burst runs, the block raises a busy output and holds off writes and the prescaler.

Top module: `clock_calendar_ctr`

## Requirements
- R1: After reset the fields read as 00:00:00, day 1, month 1, year 00; adv_busy and rd_valid are low.
- R2: Legal ranges are seconds 0..59, minutes 0..59, hours 0..23, day 1..31, month 1..12 and year 0..99. A write whose value lies outside the range of its field leaves every field unchanged.
- R3: wr_sel selects the field: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year. A legal write sampled at a clock edge is visible in a read captured at any later edge. Codes 6 and 7 change nothing.
- R4: The seconds field advances once every SUB_PER_SEC sub_tick strobes (default 4). An accepted write clears the prescaler, so a full SUB_PER_SEC strobes must follow the write before the next second.
- R5: A second tick at 59 seconds sets seconds to 0 and adds one minute. Minute 59 carries into the hour in the same way, and hour 23 carries into the day. Loading 23:59:00 and advancing 60 seconds gives 00:00:00 of the next day.
- R6: The day wraps to 1 and the month advances after day 30 in April, June, September and November, and after day 31 in the other months apart from February. For example, January 31 rolls to February 1.
- R7: February ends after day 29 when the year is divisible by 4, and after day 28 otherwise.
- R8: December 31 at 23:59:59 rolls to January 1 at 00:00:00 of the next year. Year 99 rolls to year 00.
- R9: A pulse on adv_req while idle raises adv_busy from the next cycle for exactly ADV_TICKS cycles (default 60), applying one second tick per cycle. adv_req and sub_tick are ignored while adv_busy is high.
- R10: Writes are ignored while adv_busy is high.
- R11: rd_req captures all six fields at one edge, and rd_valid is high for the following cycle. The snapshot outputs hold until the next rd_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | Sub-second strobe feeding the prescaler |
| adv_req | input | 1 | Request a burst of ADV_TICKS second ticks |
| adv_busy | output | 1 | Burst in progress |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code |
| wr_data | input | 7 | Binary value to load |
| rd_req | input | 1 | Capture a snapshot |
| rd_valid | output | 1 | Snapshot updated in the previous edge |
| rd_sec | output | 6 | Snapshot seconds |
| rd_min | output | 6 | Snapshot minutes |
| rd_hour | output | 5 | Snapshot hours |
| rd_day | output | 5 | Snapshot day of month |
| rd_mon | output | 4 | Snapshot month |
| rd_year | output | 7 | Snapshot two-digit year |

## Verification
The hardest condition to reach is a carry that ripples through all six fields. At one second per prescaler period, that carry would take a century of counted seconds to arrive. The stimulus loads each field to a value one minute short of the boundary under test, then fires a single test-advance burst. The burst itself is checked by counting the cycles adv_busy is high. A second advance request and a write are placed in the middle of a burst to show that neither lengthens the burst nor changes a field.

// File: rtl/clkcal_pkg.sv
`timescale 1ns/1ps
package clkcal_pkg;
  localparam int SEL_W  = 3;
  localparam int WDAT_W = 7;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] mins;
    logic [5:0] secs;
  } caltime_t;

  localparam caltime_t CAL_RESET = '{year: 7'd0, mon: 4'd1, day: 5'd1,
                                     hour: 5'd0, mins: 6'd0, secs: 6'd0};

  // number of days in a month; leap rule applied to the two-digit year
  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] d;
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
      4'd2:                    d = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 d = 5'd31;
    endcase
    return d;
  endfunction

  // is a value legal for the selected field
  function automatic logic field_legal(input logic [SEL_W-1:0] sel, input logic [WDAT_W-1:0] v);
    logic ok;
    case (sel)
      3'd0, 3'd1: ok = (v <= 7'd59);
      3'd2:       ok = (v <= 7'd23);
      3'd3:       ok = (v >= 7'd1) && (v <= 7'd31);
      3'd4:       ok = (v >= 7'd1) && (v <= 7'd12);
      3'd5:       ok = (v <= 7'd99);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/cal_tick_gen.sv
`timescale 1ns/1ps
module cal_tick_gen #(
  parameter int SUB_PER_SEC = 4,
  parameter int ADV_TICKS   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic adv_req,
  input  logic presc_clr,
  output logic sec_tick,
  output logic adv_busy
);
  localparam int PW = (SUB_PER_SEC > 2) ? $clog2(SUB_PER_SEC) : 1;
  localparam int AW = (ADV_TICKS > 2) ? $clog2(ADV_TICKS) : 1;

  logic [PW-1:0] presc;
  logic [AW-1:0] burst_cnt;
  logic          presc_wrap;
  logic          burst_last;

  assign presc_wrap = sub_tick && !adv_busy && (presc == PW'(SUB_PER_SEC - 1));
  assign burst_last = adv_busy && (burst_cnt == AW'(ADV_TICKS - 1));
  assign sec_tick   = adv_busy || (presc_wrap && !presc_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (presc_clr) begin
      presc <= '0;
    end else if (sub_tick && !adv_busy) begin
      presc <= presc_wrap ? '0 : presc + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_busy  <= 1'b0;
      burst_cnt <= '0;
    end else if (!adv_busy) begin
      if (adv_req) begin
        adv_busy  <= 1'b1;
        burst_cnt <= '0;
      end
    end else begin
      burst_cnt <= burst_cnt + AW'(1);
      if (burst_last) adv_busy <= 1'b0;
    end
  end

  // R9: burst ends after its last tick
  p_burst_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |=> !adv_busy);
  // R9: prescaler frozen while a burst runs
  p_presc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_busy && !presc_clr) |=> $stable(presc));
  // R4: no second tick without a strobe or a burst
  p_tick_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_busy && !sub_tick) |-> !sec_tick);
  // R9: idle request starts a burst
  p_burst_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_busy && adv_req) |=> (adv_busy && burst_cnt == '0));
endmodule

// File: rtl/cal_field_chain.sv
`timescale 1ns/1ps
module cal_field_chain
  import clkcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WDAT_W-1:0] wr_data,
  output logic              wr_taken,
  output caltime_t          now
);
  logic     c_sec, c_min, c_hour, c_day, c_mon;
  logic     adv;
  caltime_t nxt;

  assign wr_taken = wr_en && field_legal(wr_sel, wr_data);
  assign adv      = tick && !wr_taken;

  assign c_sec  = adv && (now.secs == 6'd59);
  assign c_min  = c_sec && (now.mins == 6'd59);
  assign c_hour = c_min && (now.hour == 5'd23);
  assign c_day  = c_hour && (now.day >= month_days(now.mon, now.year));
  assign c_mon  = c_day && (now.mon == 4'd12);

  always_comb begin
    nxt = now;
    if (wr_taken) begin
      case (wr_sel)
        3'd0:    nxt.secs = wr_data[5:0];
        3'd1:    nxt.mins = wr_data[5:0];
        3'd2:    nxt.hour = wr_data[4:0];
        3'd3:    nxt.day  = wr_data[4:0];
        3'd4:    nxt.mon  = wr_data[3:0];
        default: nxt.year = wr_data;
      endcase
    end else if (adv) begin
      nxt.secs = c_sec ? 6'd0 : now.secs + 6'd1;
      if (c_sec)  nxt.mins = c_min  ? 6'd0 : now.mins + 6'd1;
      if (c_min)  nxt.hour = c_hour ? 5'd0 : now.hour + 5'd1;
      if (c_hour) nxt.day  = c_day  ? 5'd1 : now.day + 5'd1;
      if (c_day)  nxt.mon  = c_mon  ? 4'd1 : now.mon + 4'd1;
      if (c_mon)  nxt.year = (now.year == 7'd99) ? 7'd0 : now.year + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= CAL_RESET;
    else        now <= nxt;
  end

  // R2: every field stays in range
  p_ranges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (now.secs <= 6'd59) && (now.mins <= 6'd59) && (now.hour <= 5'd23) &&
    (now.day >= 5'd1) && (now.day <= 5'd31) && (now.mon >= 4'd1) &&
    (now.mon <= 4'd12) && (now.year <= 7'd99));
  // R5: minute follows a seconds wrap
  p_min_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_sec && !c_min) |=> (now.secs == 6'd0 && now.mins == $past(now.mins) + 6'd1));
  // R5: new day starts at midnight
  p_midnight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_hour |=> (now.hour == 5'd0 && now.mins == 6'd0 && now.secs == 6'd0));
  // R8: end of century wraps to 00 January 1
  p_century_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mon && now.year == 7'd99) |=> (now.year == 7'd0 && now.mon == 4'd1 && now.day == 5'd1));
  // R3: fields hold with neither tick nor write
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_taken) |=> $stable(now));
endmodule

// File: rtl/cal_snapshot.sv
`timescale 1ns/1ps
module cal_snapshot
  import clkcal_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_req,
  input  caltime_t now,
  output caltime_t snap,
  output logic     rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= CAL_RESET;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) snap <= now;
    end
  end

  // R11: snapshot holds between reads
  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(snap));
  // R11: capture follows request by one edge
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && snap == $past(now)));
endmodule

// File: rtl/clock_calendar_ctr.sv
`timescale 1ns/1ps
module clock_calendar_ctr
  import clkcal_pkg::*;
#(
  parameter int SUB_PER_SEC = 4,
  parameter int ADV_TICKS   = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_tick,
  input  logic        adv_req,
  output logic        adv_busy,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [6:0]  wr_data,
  input  logic        rd_req,
  output logic        rd_valid,
  output logic [5:0]  rd_sec,
  output logic [5:0]  rd_min,
  output logic [4:0]  rd_hour,
  output logic [4:0]  rd_day,
  output logic [3:0]  rd_mon,
  output logic [6:0]  rd_year
);
  logic     wr_gated;
  logic     wr_taken;
  logic     sec_tick;
  caltime_t now;
  caltime_t snap;

  assign wr_gated = wr_en && !adv_busy;

  cal_tick_gen #(.SUB_PER_SEC(SUB_PER_SEC), .ADV_TICKS(ADV_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .adv_req(adv_req),
    .presc_clr(wr_taken), .sec_tick(sec_tick), .adv_busy(adv_busy));

  cal_field_chain u_chain (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .wr_en(wr_gated),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_taken(wr_taken), .now(now));

  cal_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .now(now),
    .snap(snap), .rd_valid(rd_valid));

  assign rd_sec  = snap.secs;
  assign rd_min  = snap.mins;
  assign rd_hour = snap.hour;
  assign rd_day  = snap.day;
  assign rd_mon  = snap.mon;
  assign rd_year = snap.year;

  // R10: no write is accepted during a burst
  p_busy_blocks_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv_busy |-> !wr_taken);
endmodule

// File: tb/test_clock_calendar_ctr.sv
`timescale 1ns/1ps
module test_clock_calendar_ctr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, adv_req = 1'b0, wr_en = 1'b0, rd_req = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [6:0] wr_data = '0;
  logic adv_busy, rd_valid;
  logic [5:0] rd_sec, rd_min;
  logic [4:0] rd_hour, rd_day;
  logic [3:0] rd_mon;
  logic [6:0] rd_year;
  int n_tests = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clock_calendar_ctr i_clock_calendar_ctr (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .adv_req(adv_req),
    .adv_busy(adv_busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_min(rd_min),
    .rd_hour(rd_hour), .rd_day(rd_day), .rd_mon(rd_mon), .rd_year(rd_year));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input int y, mo, d, h, mi, s);
    return {25'd0, 7'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic wr(input int sel, input int val);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 7'(val);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_time(input int y, mo, d, h, mi, s);
    wr(5, y); wr(4, mo); wr(3, d); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  task automatic rd_chk(input string tag, input int y, mo, d, h, mi, s);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk({tag, " rd_valid"}, 64'(rd_valid), 64'd1);
    chk(tag, pack(rd_year, rd_mon, rd_day, rd_hour, rd_min, rd_sec), pack(y, mo, d, h, mi, s));
  endtask

  task automatic sub_pulse();
    @(negedge clk); sub_tick = 1'b1;
    @(negedge clk); sub_tick = 1'b0;
  endtask

  task automatic advance(output int busy_cycles);
    @(negedge clk); adv_req = 1'b1;
    @(negedge clk); adv_req = 1'b0;
    busy_cycles = 0;
    while (adv_busy && busy_cycles < 1000) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", 64'(adv_busy), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    rd_chk("R1 reset fields", 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_write_and_legality();
    set_time(42, 7, 15, 13, 45, 30);
    rd_chk("R3 field writes", 42, 7, 15, 13, 45, 30);
    wr(6, 5); wr(7, 3);
    rd_chk("R3 unused codes", 42, 7, 15, 13, 45, 30);
    wr(0, 60); wr(2, 24); wr(3, 0); wr(4, 0); wr(4, 13); wr(5, 100);
    rd_chk("R2 illegal values", 42, 7, 15, 13, 45, 30);
  endtask

  task automatic t_prescaler();
    wr(0, 10);
    for (int i = 0; i < 3; i++) sub_pulse();
    rd_chk("R4 before period", 42, 7, 15, 13, 45, 10);
    sub_pulse();
    rd_chk("R4 one second", 42, 7, 15, 13, 45, 11);
    sub_pulse(); sub_pulse();
    wr(0, 20);
    for (int i = 0; i < 3; i++) sub_pulse();
    rd_chk("R4 write clears prescaler", 42, 7, 15, 13, 45, 20);
    sub_pulse();
    rd_chk("R4 after cleared period", 42, 7, 15, 13, 45, 21);
  endtask

  task automatic t_rollover(input string tag, input int y, mo, d, h, mi,
                            input int ey, emo, ed, eh, emi);
    int bc;
    set_time(y, mo, d, h, mi, 0);
    advance(bc);
    rd_chk(tag, ey, emo, ed, eh, emi, 0);
  endtask

  task automatic t_burst_length();
    int bc;
    set_time(10, 3, 3, 10, 20, 0);
    advance(bc);
    chk("R9 busy cycle count", 64'(bc), 64'd60);
    rd_chk("R9 one minute added", 10, 3, 3, 10, 21, 0);
  endtask

  task automatic t_busy_guard();
    int bc;
    @(negedge clk); adv_req = 1'b1;
    @(negedge clk); adv_req = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy mid burst", 64'(adv_busy), 64'd1);
    adv_req = 1'b1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 7'd5; sub_tick = 1'b1;
    @(negedge clk);
    adv_req = 1'b0; wr_en = 1'b0; sub_tick = 1'b0;
    bc = 6;
    while (adv_busy && bc < 1000) begin bc++; @(negedge clk); end
    chk("R9 request during burst ignored", 64'(bc), 64'd60);
    repeat (3) @(negedge clk);
    chk("R9 no second burst", 64'(adv_busy), 64'd0);
    rd_chk("R10 write during burst ignored", 10, 3, 3, 10, 22, 0);
  endtask

  task automatic t_snapshot_hold();
    rd_chk("R11 capture", 10, 3, 3, 10, 22, 0);
    wr(1, 5);
    chk("R11 rd_valid one cycle", 64'(rd_valid), 64'd0);
    chk("R11 snapshot held", 64'(rd_min), 64'd22);
    rd_chk("R11 new capture", 10, 3, 3, 10, 5, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_and_legality();
    t_prescaler();
    t_rollover("R5 minute step", 0, 1, 1, 0, 0, 0, 1, 1, 0, 1);
    t_rollover("R5 hour carry", 0, 1, 1, 0, 59, 0, 1, 1, 1, 0);
    t_rollover("R5 next day", 0, 1, 1, 23, 59, 0, 1, 2, 0, 0);
    t_rollover("R6 Jan 31", 0, 1, 31, 23, 59, 0, 2, 1, 0, 0);
    t_rollover("R6 Apr 30", 3, 4, 30, 23, 59, 3, 5, 1, 0, 0);
    t_rollover("R6 Nov 30", 3, 11, 30, 23, 59, 3, 12, 1, 0, 0);
    t_rollover("R7 Feb 28 common", 1, 2, 28, 23, 59, 1, 3, 1, 0, 0);
    t_rollover("R7 Feb 28 leap", 4, 2, 28, 23, 59, 4, 2, 29, 0, 0);
    t_rollover("R7 Feb 29 leap", 4, 2, 29, 23, 59, 4, 3, 1, 0, 0);
    t_rollover("R8 year end", 5, 12, 31, 23, 59, 6, 1, 1, 0, 0);
    t_rollover("R8 century wrap", 99, 12, 31, 23, 59, 0, 1, 1, 0, 0);
    t_burst_length();
    t_busy_guard();
    t_snapshot_hold();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule